// File: doc/BRIEF.md
# Signed 16x16 Multiply-Accumulate Unit

This block is the multiply datapath of a 32-bit register-based core. On a start strobe it takes two 32-bit register operands and an operation code. It multiplies the low 16-bit halves of the two operands, either as unsigned values or as two's-complement values. Depending on the operation, it either writes the 32-bit product back to the register file, or loads or adds it into a private 32-bit accumulator.

A multiply-accumulate group has three steps. It opens with a signed multiply that replaces the accumulator. Any number of signed multiply-adds follow. A readout then copies the accumulator to a destination register. The two accumulator-only operations finish in one cycle. The register-writing operations take three cycles. Every operation ends with a single-cycle done pulse, and a writeback enable marks the operations whose result goes to a register. The issuing logic must not raise start again until done has pulsed.

Top module: `mac16_unit`

## Requirements
- R1: After reset, done_o, wb_o and flags_we_o are low and the accumulator holds zero, so a readout issued right after reset returns 0.
- R2: Operation code 0 (unsigned multiply) writes the 32-bit product of src_a[15:0] and src_b[15:0], both taken as unsigned values. Bits 31:16 of both operands have no effect.
- R3: Operation code 1 (signed multiply) writes the 32-bit two's-complement product of src_a[15:0] and src_b[15:0], both taken as signed values. Bits 31:16 of both operands have no effect.
- R4: Codes 0 and 1 raise flags_we_o in their done cycle. In that cycle z_o is 1 exactly when result_o is zero, and n_o equals result_o[31]. No other code raises flags_we_o or changes z_o or n_o.
- R5: Operation code 2 replaces the accumulator with the signed product of the low halves. It does not assert wb_o.
- R6: Operation code 3 adds the signed product of the low halves to the accumulator, wrapping modulo 2^32. It does not assert wb_o. The accumulator changes only in the done cycle of code 2 or code 3.
- R7: Operation code 4 drives the 32-bit accumulator on result_o with wb_o high. It leaves the accumulator, z_o and n_o unchanged.
- R8: Codes 0, 1 and 4 raise done_o in the third cycle after the start cycle. Codes 2, 3 and the unused codes raise it in the first cycle after. done_o lasts one cycle.
- R9: wb_o is high only in a done cycle, and only for codes 0, 1 and 4.
- R10: Codes 5 to 7 complete like a one-cycle operation. They assert neither wb_o nor flags_we_o and leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; sampled on the rising edge |
| op | input | 3 | Operation code, sampled with start |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| result_o | output | 32 | Writeback value, valid when wb_o is high |
| wb_o | output | 1 | Register writeback enable, one cycle |
| z_o | output | 1 | Zero flag, held between updates |
| n_o | output | 1 | Negative flag, held between updates |
| flags_we_o | output | 1 | Flag update strobe, one cycle |
| done_o | output | 1 | Operation complete pulse |

## Verification
The bound checker tracks every start and checks each cycle the following properties:
- each done arrives after the latency of its recorded operation code;
- writeback and flag strobes occur only inside done cycles;
- the flags match the written result;
- the accumulator moves only when an operation finishes;
- a readout returns the accumulator and does not touch the flags.

Only the bench scenarios can show the arithmetic values themselves. These include:
- unsigned against signed interpretation of the low halves;
- products at the 16-bit extremes;
- accumulation that wraps past 2^32;
- a load that discards an earlier sum;
- proof that upper operand bits and unused codes leave results and accumulator untouched.

// File: rtl/mac16_pkg.sv
package mac16_pkg;

    localparam int unsigned OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        MOP_MULU   = 3'd0,
        MOP_MULS   = 3'd1,
        MOP_ACCLD  = 3'd2,
        MOP_ACCADD = 3'd3,
        MOP_ACCRD  = 3'd4
    } mop_e;

    // Per-operation control bundle derived from the code
    typedef struct packed {
        logic wr;     // writes a destination register
        logic flg;    // updates Z and N
        logic sgn;    // halves are two's complement
        logic ld;     // accumulator takes the product
        logic add;    // accumulator adds the product
        logic rd;     // result comes from the accumulator
    } mop_ctl_t;

    function automatic mop_ctl_t mop_decode(logic [OP_W-1:0] code);
        mop_ctl_t c;
        c = '0;
        case (code)
            MOP_MULU:   begin c.wr = 1'b1; c.flg = 1'b1; end
            MOP_MULS:   begin c.wr = 1'b1; c.flg = 1'b1; c.sgn = 1'b1; end
            MOP_ACCLD:  begin c.ld = 1'b1; c.sgn = 1'b1; end
            MOP_ACCADD: begin c.add = 1'b1; c.sgn = 1'b1; end
            MOP_ACCRD:  begin c.wr = 1'b1; c.rd = 1'b1; end
            default:    c = '0;
        endcase
        return c;
    endfunction

    // Register-writing codes take the long path
    function automatic logic mop_is_long(logic [OP_W-1:0] code);
        return (code == MOP_MULU) || (code == MOP_MULS) || (code == MOP_ACCRD);
    endfunction

endpackage

// File: rtl/mac16_product.sv
module mac16_product
    import mac16_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned HALF_W = 16
) (
    input  logic [HALF_W-1:0] half_a,
    input  logic [HALF_W-1:0] half_b,
    input  logic              sgn,
    output logic [DATA_W-1:0] prod
);
    localparam int unsigned EXT_W = DATA_W - HALF_W;

    logic [HALF_W-1:0] halves [2];
    logic [DATA_W-1:0] ext    [2];

    assign halves[0] = half_a;
    assign halves[1] = half_b;

    // Widen each half; the multiply below is exact modulo 2^DATA_W
    for (genvar i = 0; i < 2; i++) begin : g_ext
        assign ext[i] = {{EXT_W{sgn & halves[i][HALF_W-1]}}, halves[i]};
    end

    assign prod = ext[0] * ext[1];

endmodule

// File: rtl/mac16_accum.sv
module mac16_accum #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              add_en,
    input  logic [DATA_W-1:0] prod,
    output logic [DATA_W-1:0] acc_o
);
    logic [DATA_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (load_en) begin
            acc_q <= prod;
        end else if (add_en) begin
            acc_q <= acc_q + prod;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/mac16_seq.sv
module mac16_seq
    import mac16_pkg::*;
#(
    parameter int unsigned LAT_LONG  = 3,
    parameter int unsigned LAT_SHORT = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [OP_W-1:0] op,
    output logic [OP_W-1:0] op_now,
    output logic            finish_now,
    output logic            done_o
);
    localparam int unsigned CW      = $clog2(LAT_LONG + 1);
    localparam logic [CW-1:0] LONG_C  = CW'(LAT_LONG);
    localparam logic [CW-1:0] SHORT_C = CW'(LAT_SHORT);
    localparam logic [CW-1:0] ONE_C   = CW'(1);

    logic [OP_W-1:0] op_q;
    logic [CW-1:0]   cnt_q;
    logic            busy_q;
    logic            done_q;
    logic [CW-1:0]   lat_new;

    assign lat_new    = mop_is_long(op) ? LONG_C : SHORT_C;
    assign op_now     = start ? op : op_q;
    assign finish_now = (start && (lat_new == ONE_C)) ||
                        (!start && busy_q && (cnt_q == ONE_C));

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish_now;
            if (start) begin
                op_q   <= op;
                cnt_q  <= lat_new - ONE_C;
                busy_q <= (lat_new != ONE_C);
            end else if (busy_q) begin
                cnt_q <= cnt_q - ONE_C;
                if (cnt_q == ONE_C) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign done_o = done_q;

endmodule

// File: rtl/mac16_unit.sv
module mac16_unit
    import mac16_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned HALF_W    = 16,
    parameter int unsigned LAT_LONG  = 3,
    parameter int unsigned LAT_SHORT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] result_o,
    output logic              wb_o,
    output logic              z_o,
    output logic              n_o,
    output logic              flags_we_o,
    output logic              done_o
);
    logic [HALF_W-1:0] a_q, b_q, a_now, b_now;
    logic [OP_W-1:0]   op_now;
    logic              finish_now;
    mop_ctl_t          ctl;
    logic [DATA_W-1:0] prod_w, acc_w, wval;
    logic [DATA_W-1:0] result_q;
    logic              wb_q, z_q, n_q, fwe_q;
    logic              unused_hi;

    // Only the low halves take part in any operation
    assign unused_hi = ^{src_a[DATA_W-1:HALF_W], src_b[DATA_W-1:HALF_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (start) begin
            a_q <= src_a[HALF_W-1:0];
            b_q <= src_b[HALF_W-1:0];
        end
    end

    assign a_now = start ? src_a[HALF_W-1:0] : a_q;
    assign b_now = start ? src_b[HALF_W-1:0] : b_q;

    mac16_seq #(
        .LAT_LONG  (LAT_LONG),
        .LAT_SHORT (LAT_SHORT)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op         (op),
        .op_now     (op_now),
        .finish_now (finish_now),
        .done_o     (done_o)
    );

    assign ctl = mop_decode(op_now);

    mac16_product #(
        .DATA_W (DATA_W),
        .HALF_W (HALF_W)
    ) u_prod (
        .half_a (a_now),
        .half_b (b_now),
        .sgn    (ctl.sgn),
        .prod   (prod_w)
    );

    mac16_accum #(
        .DATA_W (DATA_W)
    ) u_acc (
        .clk     (clk),
        .rst     (rst),
        .load_en (finish_now & ctl.ld),
        .add_en  (finish_now & ctl.add),
        .prod    (prod_w),
        .acc_o   (acc_w)
    );

    assign wval = ctl.rd ? acc_w : prod_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            wb_q     <= 1'b0;
            fwe_q    <= 1'b0;
            z_q      <= 1'b0;
            n_q      <= 1'b0;
        end else begin
            wb_q  <= finish_now & ctl.wr;
            fwe_q <= finish_now & ctl.flg;
            if (finish_now && ctl.wr) begin
                result_q <= wval;
            end
            if (finish_now && ctl.flg) begin
                z_q <= (wval == '0);
                n_q <= wval[DATA_W-1];
            end
        end
    end

    assign result_o   = result_q;
    assign wb_o       = wb_q;
    assign flags_we_o = fwe_q;
    assign z_o        = z_q;
    assign n_o        = n_q;

endmodule

// File: rtl/mac16_checker.sv
module mac16_checker
    import mac16_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned LAT_LONG  = 3,
    parameter int unsigned LAT_SHORT = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [OP_W-1:0]   op,
    input logic [DATA_W-1:0] result_o,
    input logic              wb_o,
    input logic              z_o,
    input logic              n_o,
    input logic              flags_we_o,
    input logic              done_o,
    input logic [DATA_W-1:0] acc_val
);
    logic            pend_q;
    logic [7:0]      cyc_q;
    logic [OP_W-1:0] rec_q;
    logic [7:0]      exp_lat;
    logic            rec_acc;

    // Count cycles from each start to its done
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            cyc_q  <= '0;
            rec_q  <= '0;
        end else if (start) begin
            pend_q <= 1'b1;
            cyc_q  <= 8'd1;
            rec_q  <= op;
        end else if (done_o) begin
            pend_q <= 1'b0;
        end else if (pend_q && cyc_q != 8'hFF) begin
            cyc_q <= cyc_q + 8'd1;
        end
    end

    assign exp_lat = mop_is_long(rec_q) ? 8'(LAT_LONG) : 8'(LAT_SHORT);
    assign rec_acc = (rec_q == MOP_ACCLD) || (rec_q == MOP_ACCADD);

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (pend_q && cyc_q == exp_lat));

    assert_wb_in_done_R9: assert property (@(posedge clk) disable iff (rst)
        wb_o |-> done_o);

    assert_flags_with_wb_R4: assert property (@(posedge clk) disable iff (rst)
        flags_we_o |-> wb_o);

    assert_zero_flag_R4: assert property (@(posedge clk) disable iff (rst)
        flags_we_o |-> (z_o == (result_o == '0)));

    assert_neg_flag_R4: assert property (@(posedge clk) disable iff (rst)
        flags_we_o |-> (n_o == result_o[DATA_W-1]));

    assert_acc_no_wb_R5: assert property (@(posedge clk) disable iff (rst)
        (done_o && rec_acc) |-> !wb_o);

    assert_acc_moves_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(acc_val) |-> (done_o && rec_acc));

    assert_readout_R7: assert property (@(posedge clk) disable iff (rst)
        (done_o && rec_q == MOP_ACCRD) |-> (wb_o && !flags_we_o && result_o == acc_val));

endmodule

bind mac16_unit mac16_checker #(
    .DATA_W    (DATA_W),
    .LAT_LONG  (LAT_LONG),
    .LAT_SHORT (LAT_SHORT)
) u_mac16_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .op         (op),
    .result_o   (result_o),
    .wb_o       (wb_o),
    .z_o        (z_o),
    .n_o        (n_o),
    .flags_we_o (flags_we_o),
    .done_o     (done_o),
    .acc_val    (acc_w)
);

// File: tb/test_mac16_unit.sv
module test_mac16_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] result_o;
    logic        wb_o, z_o, n_o, flags_we_o, done_o;

    int n_checks = 0;
    int n_fail   = 0;

    // Captured at the done cycle of the last operation
    logic [31:0] c_res;
    logic        c_wb, c_fwe, c_z, c_n, c_done_after;
    int          c_lat;
    logic [31:0] model_acc;

    always #2.5 clk = ~clk;

    mac16_unit i_mac16_unit (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .op         (op),
        .src_a      (src_a),
        .src_b      (src_b),
        .result_o   (result_o),
        .wb_o       (wb_o),
        .z_o        (z_o),
        .n_o        (n_o),
        .flags_we_o (flags_we_o),
        .done_o     (done_o)
    );

    function automatic logic [31:0] umul(logic [31:0] a, logic [31:0] b);
        logic [31:0] x, y;
        x = {16'h0, a[15:0]};
        y = {16'h0, b[15:0]};
        return x * y;
    endfunction

    function automatic logic [31:0] smul(logic [31:0] a, logic [31:0] b);
        int x, y;
        x = int'($signed(a[15:0]));
        y = int'($signed(b[15:0]));
        return 32'(x * y);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] code, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        start = 1'b1; op = code; src_a = a; src_b = b;
        @(negedge clk);
        start = 1'b0; src_a = 32'hDEAD_BEEF; src_b = 32'hCAFE_F00D;
        c_lat = 1;
        while (!done_o && c_lat < 20) begin
            @(negedge clk);
            c_lat++;
        end
        c_res = result_o; c_wb = wb_o; c_fwe = flags_we_o; c_z = z_o; c_n = n_o;
        @(negedge clk);
        c_done_after = done_o;
    endtask

    task automatic read_acc(input string tag, input logic [31:0] exp);
        run_op(3'd4, 32'h0, 32'h0);
        chk({tag, " readout value"}, c_res, exp);
        chk({tag, " readout wb"}, 32'(c_wb), 32'd1);
    endtask

    task automatic t_reset;
        chk("R1 done after reset", 32'(done_o), 32'd0);
        chk("R1 wb after reset", 32'(wb_o), 32'd0);
        chk("R1 flags_we after reset", 32'(flags_we_o), 32'd0);
        read_acc("R1 zero acc", 32'd0);
    endtask

    task automatic t_unsigned;
        logic [31:0] a, b;
        a = 32'hABCD_0003; b = 32'h1234_0005;
        run_op(3'd0, a, b);
        chk("R2 umul upper bits ignored", c_res, umul(a, b));
        chk("R8 umul latency", 32'(c_lat), 32'd3);
        chk("R8 done single pulse", 32'(c_done_after), 32'd0);
        chk("R9 umul wb", 32'(c_wb), 32'd1);
        chk("R4 umul flags_we", 32'(c_fwe), 32'd1);
        a = 32'h0000_FFFF; b = 32'hFFFF_FFFF;
        run_op(3'd0, a, b);
        chk("R2 umul max", c_res, 32'hFFFE_0001);
        chk("R4 umul N set", 32'(c_n), 32'd1);
        chk("R4 umul Z clear", 32'(c_z), 32'd0);
        run_op(3'd0, 32'h1234_0000, 32'h0000_7777);
        chk("R2 umul zero", c_res, 32'd0);
        chk("R4 umul Z set", 32'(c_z), 32'd1);
    endtask

    task automatic t_signed;
        logic [31:0] a, b;
        a = 32'h5555_FFFF; b = 32'h0000_0002;
        run_op(3'd1, a, b);
        chk("R3 smul minus one", c_res, smul(a, b));
        chk("R4 smul N set", 32'(c_n), 32'd1);
        chk("R8 smul latency", 32'(c_lat), 32'd3);
        run_op(3'd1, 32'h0000_8000, 32'hFFFF_8000);
        chk("R3 smul min by min", c_res, 32'h4000_0000);
        chk("R4 smul N clear", 32'(c_n), 32'd0);
        a = 32'h0001_7FFF; b = 32'h0002_8000;
        run_op(3'd1, a, b);
        chk("R3 smul mixed sign", c_res, 32'hC000_8000);
        chk("R3 smul model", c_res, smul(a, b));
    endtask

    task automatic t_group;
        logic zf, nf;
        model_acc = smul(32'd100, 32'd3);
        run_op(3'd2, 32'hFFFF_0064, 32'h0000_0003);
        chk("R5 load no wb", 32'(c_wb), 32'd0);
        chk("R8 load latency", 32'(c_lat), 32'd1);
        chk("R4 load no flags_we", 32'(c_fwe), 32'd0);
        model_acc = model_acc + smul(32'h0000_FFFB, 32'h0000_0004);
        run_op(3'd3, 32'h0000_FFFB, 32'h0000_0004);
        chk("R6 add no wb", 32'(c_wb), 32'd0);
        chk("R8 add latency", 32'(c_lat), 32'd1);
        zf = z_o; nf = n_o;
        read_acc("R6 sum", model_acc);
        chk("R7 readout latency", 32'(c_lat), 32'd3);
        chk("R7 readout no flags_we", 32'(c_fwe), 32'd0);
        chk("R7 Z kept", 32'(c_z), 32'(zf));
        chk("R7 N kept", 32'(c_n), 32'(nf));
        read_acc("R7 acc unchanged by readout", model_acc);
        run_op(3'd0, 32'd9, 32'd9);
        read_acc("R2 umul leaves acc", model_acc);
        run_op(3'd2, 32'd7, 32'd1);
        read_acc("R5 load replaces", 32'd7);
    endtask

    task automatic t_wrap;
        run_op(3'd2, 32'h0000_8000, 32'h0000_8000);
        for (int i = 0; i < 3; i++) begin
            run_op(3'd3, 32'h0000_8000, 32'h0000_8000);
        end
        read_acc("R6 wrap to zero", 32'd0);
        run_op(3'd3, 32'h0000_7FFF, 32'h0000_7FFF);
        read_acc("R6 add after wrap", 32'h3FFF_0001);
    endtask

    task automatic t_unused;
        for (int code = 5; code < 8; code++) begin
            run_op(3'(code), 32'd3, 32'd5);
            chk("R10 unused latency", 32'(c_lat), 32'd1);
            chk("R10 unused no wb", 32'(c_wb), 32'd0);
            chk("R10 unused no flags_we", 32'(c_fwe), 32'd0);
        end
        read_acc("R10 acc untouched", 32'h3FFF_0001);
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unsigned();
        t_signed();
        t_group();
        t_wrap();
        t_unused();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule